// File: doc/BRIEF.md
# SPI FIFO Occupancy and Receive Idle Monitor

This block sits beside the transmit and receive FIFOs of an SPI controller and keeps a running count of how many entries each one holds. It sees only the push and pop strobes of each FIFO, never the data. From the two counts it builds a 32-bit status word that also carries full and empty indications for both FIFOs.

The block also watches for a stalled receive path. Data may sit in the receive FIFO while software fails to collect it. When that lasts past a mode-dependent limit, a time-out flag rises. In master mode the limit is 64 SPI clock periods, counted on cycles where the SPI clock tick enable is high. In slave mode the limit is 576 peripheral clock cycles. The flag stays up until software reads the receive FIFO. The serial shifter, FIFO storage, clock generation and bus access all live elsewhere.

Top module: `spi_fifo_status_top`

## Requirements
- R1: After reset the status word is 0x0500_0000 and the time-out output is 0.
- R2: Status bits [31:28] hold the transmit entry count (0 to 8). Bit 27 is 1 exactly when that count is 8, and bit 26 is 1 exactly when it is 0.
- R3: Status bits [15:12] hold the receive entry count (0 to 8). Bit 25 is 1 exactly when that count is 8, and bit 24 is 1 exactly when it is 0.
- R4: A push into a FIFO holding 8 entries does not change its count. A pop from an empty FIFO does not change its count either.
- R5: A push and a pop on the same FIFO in the same cycle leave its count unchanged.
- R6: Status bits [23:21], [19:16] and [11:0] always read as 0.
- R7: In master mode (master_mode=1), the time-out sets on the 64th cycle with sclk_tick=1 while the receive FIFO is non-empty and no read has occurred. Cycles with sclk_tick=0 do not count.
- R8: In slave mode (master_mode=0), the time-out sets on the 576th clock with the receive FIFO non-empty and no read.
- R9: A pulse on rx_sw_read clears the time-out at the next edge and restarts the idle count from zero.
- R10: While the receive FIFO is empty the idle count is held at zero, so the time-out never sets on an empty FIFO.
- R11: rx_flush sets the receive count to 0 and overrides any push or pop in that cycle. A time-out that is already set stays set through a flush, until the next rx_sw_read.
- R12: Status bit 20 always equals the rx_timeout output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_flush | input | 1 | Receive FIFO pointer reset |
| rx_sw_read | input | 1 | Software read of the receive FIFO |
| master_mode | input | 1 | 1 = master, 0 = slave |
| sclk_tick | input | 1 | One-cycle enable per SPI clock period |
| status_word | output | 32 | Packed occupancy and time-out status |
| rx_timeout | output | 1 | Receive idle time-out flag |

## Verification
Every cycle, the assertions check that the counts stay in range, that a rejected push or pop and a simultaneous push and pop leave a count where it was, that a read always clears the flag, and that the flag can neither rise nor set while the receive FIFO is empty. Only the bench scenarios can show the exact cycle on which the flag rises in each mode. The same goes for ignoring non-tick cycles in master mode, persistence through a flush, and the packing of every field of the status word. A reference model driven with long random strobe sequences, plus directed runs at the 575/576 and 63/64 boundaries, covers these.

// File: rtl/spi_fifo_status_pkg.sv
package spi_fifo_status_pkg;
    localparam int FIFO_DEPTH   = 8;
    localparam int LVL_W        = 4;
    localparam int MASTER_LIMIT = 64;
    localparam int SLAVE_LIMIT  = 576;
    localparam int IDLE_W       = $clog2(SLAVE_LIMIT + 1);

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } lvl_state_t;

    typedef struct packed {
        logic [IDLE_W-1:0] idle;
        logic              flag;
    } idle_state_t;
endpackage

// File: rtl/fifo_level_trk.sv
module fifo_level_trk
    import spi_fifo_status_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clr,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.level = '0;
        end else if (push && pop) begin
            st_d.level = st_q.level;
        end else if (push && (st_q.level != TOP)) begin
            st_d.level = st_q.level + 1'b1;
        end else if (pop && (st_q.level != '0)) begin
            st_d.level = st_q.level - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign full  = (st_q.level == TOP);
    assign empty = (st_q.level == '0);

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= TOP);
    p_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (level == TOP));
    p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (level == '0));
    p_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clr) |=> $stable(level));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import spi_fifo_status_pkg::*;
#(
    parameter int M_LIMIT = MASTER_LIMIT,
    parameter int S_LIMIT = SLAVE_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_empty,
    input  logic rd,
    input  logic master,
    input  logic tick,
    output logic flag
);
    localparam logic [IDLE_W-1:0] M_LAST = IDLE_W'(M_LIMIT - 1);
    localparam logic [IDLE_W-1:0] S_LAST = IDLE_W'(S_LIMIT - 1);

    idle_state_t st_d, st_q;
    logic              adv;
    logic              hit;
    logic [IDLE_W-1:0] last;

    always_comb begin
        st_d = st_q;
        adv  = master ? tick : 1'b1;
        last = master ? M_LAST : S_LAST;
        hit  = 1'b0;
        if (rd) begin
            st_d.idle = '0;
            st_d.flag = 1'b0;
        end else if (rx_empty) begin
            st_d.idle = '0;
        end else if (adv) begin
            if (st_q.idle >= last) begin
                hit = 1'b1;
            end else begin
                st_d.idle = st_q.idle + 1'b1;
            end
        end
        if (hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !flag);
    p_empty_no_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !flag) |=> !flag);
    p_rise_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(!rx_empty && !rd));
endmodule

// File: rtl/spi_fifo_status_top.sv
module spi_fifo_status_top
    import spi_fifo_status_pkg::*;
#(
    parameter int DEPTH   = FIFO_DEPTH,
    parameter int M_LIMIT = MASTER_LIMIT,
    parameter int S_LIMIT = SLAVE_LIMIT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic        rx_pop,
    input  logic        rx_flush,
    input  logic        rx_sw_read,
    input  logic        master_mode,
    input  logic        sclk_tick,
    output logic [31:0] status_word,
    output logic        rx_timeout
);
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic tx_full, tx_empty, rx_full, rx_empty;

    fifo_level_trk #(.DEPTH(DEPTH)) u_tx_lvl (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .clr(1'b0),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    fifo_level_trk #(.DEPTH(DEPTH)) u_rx_lvl (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .clr(rx_flush),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    rx_idle_timer #(.M_LIMIT(M_LIMIT), .S_LIMIT(S_LIMIT)) u_idle (
        .clk(clk), .rst_n(rst_n), .rx_empty(rx_empty), .rd(rx_sw_read),
        .master(master_mode), .tick(sclk_tick), .flag(rx_timeout)
    );

    always_comb begin
        status_word          = '0;
        status_word[31:28]   = tx_lvl;
        status_word[27]      = tx_full;
        status_word[26]      = tx_empty;
        status_word[25]      = rx_full;
        status_word[24]      = rx_empty;
        status_word[20]      = rx_timeout;
        status_word[15:12]   = rx_lvl;
    end

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> status_word[24]);
    p_flag_survives_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && rx_flush && !rx_sw_read) |=> rx_timeout);
endmodule

// File: tb/spi_fifo_status_top_tb_top.sv
module spi_fifo_status_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic rx_flush = 0, rx_sw_read = 0, master_mode = 0, sclk_tick = 0;
    logic [31:0] status_word;
    logic rx_timeout;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int m_tx = 0, m_rx = 0, m_idle = 0;
    bit m_flag = 0;

    always #10 clk = ~clk;

    spi_fifo_status_top dut_i (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .rx_flush(rx_flush),
        .rx_sw_read(rx_sw_read), .master_mode(master_mode),
        .sclk_tick(sclk_tick), .status_word(status_word), .rx_timeout(rx_timeout)
    );

    function automatic logic [31:0] exp_word(int t, int r, bit f);
        logic [31:0] w = '0;
        w[31:28] = 4'(t);
        w[27] = (t == 8);
        w[26] = (t == 0);
        w[25] = (r == 8);
        w[24] = (r == 0);
        w[20] = f;
        w[15:12] = 4'(r);
        return w;
    endfunction

    function automatic int next_lvl(int l, bit pu, bit po);
        if (pu && po) return l;
        if (pu && l < 8) return l + 1;
        if (po && l > 0) return l - 1;
        return l;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic model_update();
        int thr = master_mode ? 64 : 576;
        bit adv = master_mode ? sclk_tick : 1'b1;
        bit was_empty = (m_rx == 0);
        m_tx = next_lvl(m_tx, tx_push, tx_pop);
        m_rx = rx_flush ? 0 : next_lvl(m_rx, rx_push, rx_pop);
        if (rx_sw_read) begin
            m_idle = 0; m_flag = 0;
        end else if (was_empty) begin
            m_idle = 0;
        end else if (adv) begin
            if (m_idle >= thr - 1) m_flag = 1;
            else m_idle++;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_in();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        rx_flush = 0; rx_sw_read = 0; sclk_tick = 0;
    endtask

    task automatic cmp_model(string req);
        logic [31:0] e = exp_word(m_tx, m_rx, m_flag);
        chk(status_word == e, req, status_word, e);
        chk(rx_timeout == m_flag, "R12", 32'(rx_timeout), 32'(m_flag));
        chk(status_word[20] == rx_timeout, "R12", 32'(status_word[20]), 32'(rx_timeout));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(status_word == 32'h0500_0000, "R1", status_word, 32'h0500_0000);
        chk(rx_timeout == 1'b0, "R1", 32'(rx_timeout), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4: fill transmit side beyond 8
        for (int i = 0; i < 10; i++) begin idle_in(); tx_push = 1; step(); end
        idle_in();
        chk(status_word[31:26] == 6'b1000_10, "R2", status_word, exp_word(8, 0, 0));
        chk(status_word[31:28] == 4'd8, "R4", status_word, exp_word(8, 0, 0));
        // R5: push and pop together while full
        tx_push = 1; tx_pop = 1; step(); idle_in();
        chk(status_word[31:28] == 4'd8, "R5", status_word, exp_word(8, 0, 0));
        for (int i = 0; i < 9; i++) begin idle_in(); tx_pop = 1; step(); end
        idle_in();
        chk(status_word == 32'h0500_0000, "R4", status_word, 32'h0500_0000);

        // R3/R5: receive side
        for (int i = 0; i < 8; i++) begin idle_in(); rx_push = 1; rx_sw_read = 1; step(); end
        idle_in();
        chk(status_word[25:24] == 2'b10 && status_word[15:12] == 4'd8, "R3",
            status_word, exp_word(0, 8, 0));
        rx_push = 1; rx_pop = 1; rx_sw_read = 1; step(); idle_in();
        chk(status_word[15:12] == 4'd8, "R5", status_word, exp_word(0, 8, 0));
        rx_flush = 1; rx_push = 1; rx_sw_read = 1; step(); idle_in();
        chk(status_word == 32'h0500_0000, "R11", status_word, 32'h0500_0000);

        // R10: empty receive FIFO in slave mode never times out
        master_mode = 0;
        repeat (700) step();
        chk(rx_timeout == 0, "R10", 32'(rx_timeout), 32'h0);

        // R8: slave time-out at 576 clocks
        rx_push = 1; step(); idle_in();
        repeat (575) step();
        chk(rx_timeout == 0, "R8", 32'(rx_timeout), 32'h0);
        step();
        chk(rx_timeout == 1, "R8", 32'(rx_timeout), 32'h1);
        chk(status_word == 32'h0410_1000, "R6", status_word, 32'h0410_1000);

        // R11: flush keeps flag; R9: read clears it
        rx_flush = 1; step(); idle_in();
        chk(rx_timeout == 1 && status_word[24] == 1, "R11", status_word, 32'h0510_0000);
        rx_sw_read = 1; step(); idle_in();
        chk(rx_timeout == 0, "R9", 32'(rx_timeout), 32'h0);

        // R7: master mode, tick every other cycle
        master_mode = 1;
        rx_push = 1; step(); idle_in();
        for (int i = 0; i < 63; i++) begin sclk_tick = 1; step(); sclk_tick = 0; step(); end
        chk(rx_timeout == 0, "R7", 32'(rx_timeout), 32'h0);
        repeat (20) step();
        chk(rx_timeout == 0, "R7", 32'(rx_timeout), 32'h0);
        sclk_tick = 1; step(); sclk_tick = 0;
        chk(rx_timeout == 1, "R7", 32'(rx_timeout), 32'h1);
        // R9: read restarts the count
        rx_sw_read = 1; step(); idle_in();
        for (int i = 0; i < 63; i++) begin sclk_tick = 1; step(); end
        idle_in();
        chk(rx_timeout == 0, "R9", 32'(rx_timeout), 32'h0);
        sclk_tick = 1; step(); idle_in();
        chk(rx_timeout == 1, "R9", 32'(rx_timeout), 32'h1);
        cmp_model("R2");

        // Constrained random against the model
        for (int i = 0; i < 6000; i++) begin
            tx_push     = ($urandom % 3) == 0;
            tx_pop      = ($urandom % 3) == 0;
            rx_push     = ($urandom % 4) == 0;
            rx_pop      = ($urandom % 4) == 0;
            rx_flush    = ($urandom % 300) == 0;
            rx_sw_read  = ($urandom % 150) == 0;
            sclk_tick   = ($urandom % 2) == 0;
            if (($urandom % 1000) == 0) master_mode = ~master_mode;
            step();
            cmp_model("R6");
        end
        idle_in();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule